// File: doc/BRIEF.md
# High/Low Time Programmable Clock Divider

This block derives a slower clock from its input clock. A 15-bit control word names two phase lengths in input cycles: the number of cycles the output stays high, then the number it stays low. One output period therefore spans their sum. A bypass flag in the word hands the input clock straight to the output, for a ratio of one. An edge flag marks odd ratios for the encoder's benefit. The divider itself does not use it.

A new word is presented together with a one-cycle load strobe. It is held as a pending word and becomes active only at the input edge that closes a low phase. Every output period therefore runs to completion and no shortened pulse appears. A word whose no-update flag is set is discarded. A readback output always shows the ratio that is currently active.

Top module: `hlclk_div`

## Requirements
- R1: While the active-low reset is asserted, the divided clock is low and the ratio readback is 1, because reset restores bypass with both phase lengths at 1.
- R2: When the active word has bypass (bit 13) set, the divided clock equals the input clock and the readback is 1, whatever the phase fields hold.
- R3: With bypass clear, each output period starts high for H input cycles, then stays low for L input cycles, and the readback is H+L. H is bits 11:6 and L is bits 5:0. Each takes values from 1 to 63, so the ratio ranges from 2 to 126.
- R4: A word encoded for an odd ratio N, with H = floor(N/2) and L = ceil(N/2), gives an output whose low phase is one cycle longer than its high phase, and the readback is N.
- R5: A phase field of 0, with bypass clear, behaves exactly as a field of 1.
- R6: A loaded word becomes active only on the input rising edge that ends a low phase. In bypass, it becomes active on the next rising edge after it is captured. The readback changes only at such an edge.
- R7: A load whose word has the no-update flag (bit 14) set has no effect: the active ratio and the waveform stay as they were.
- R8: The edge flag (bit 12) has no effect on the waveform or the readback.
- R9: When several accepted loads arrive before a period boundary, only the last one becomes active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctrl_i | input | 15 | Control word: L[5:0], H[11:6], edge[12], bypass[13], no-update[14] |
| load_i | input | 1 | One-cycle strobe that captures ctrl_i on a rising edge |
| clk_div_o | output | 1 | Divided clock |
| ratio_o | output | 7 | Currently active division ratio |

## Verification
The hardest case to reach from the ports is a word that arrives while a period is in progress. It must sit pending until the low phase closes, and it may be overwritten before then. The stimulus strobes loads at arbitrary cycles against long periods, issues two accepted loads back to back, and switches between bypass and divided operation in both directions. A behavioural reference model follows the phase and pending state on every edge, and the output and readback are compared against it in both halves of each input cycle.

// File: rtl/hlclk_pkg.sv
package hlclk_pkg;
   typedef enum logic {
      PH_LOW  = 1'b0,
      PH_HIGH = 1'b1
   } phase_e;

   // Bit positions inside the control word, derived from the field width.
   function automatic int unsigned pos_edge(int unsigned fw);
      return 2 * fw;
   endfunction

   function automatic int unsigned pos_bypass(int unsigned fw);
      return 2 * fw + 1;
   endfunction

   function automatic int unsigned pos_noupd(int unsigned fw);
      return 2 * fw + 2;
   endfunction
endpackage

// File: rtl/hlclk_word_hold.sv
module hlclk_word_hold #(
   parameter int unsigned FIELD_W = 6,
   localparam int unsigned CTRL_W = 2 * FIELD_W + 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [CTRL_W-1:0] word,
   input  logic              take,
   output logic [CTRL_W-1:0] pend_word,
   output logic              pend_valid
);
   localparam int unsigned NOUPD_BIT = hlclk_pkg::pos_noupd(FIELD_W);

   logic accept;
   assign accept = load & ~word[NOUPD_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_word  <= '0;
         pend_valid <= 1'b0;
      end else if (accept) begin
         pend_word  <= word;
         pend_valid <= 1'b1;
      end else if (take) begin
         pend_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/hlclk_cfg_reg.sv
module hlclk_cfg_reg #(
   parameter int unsigned FIELD_W = 6,
   localparam int unsigned CTRL_W = 2 * FIELD_W + 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               take,
   input  logic [CTRL_W-1:0]  word,
   output logic [FIELD_W-1:0] hi_lim,
   output logic [FIELD_W-1:0] lo_lim,
   output logic               bypass
);
   localparam int unsigned BYP_BIT = hlclk_pkg::pos_bypass(FIELD_W);

   logic [FIELD_W-1:0] raw   [2];
   logic [FIELD_W-1:0] eff   [2];
   logic [FIELD_W-1:0] act_q [2];

   assign raw[0] = word[FIELD_W-1:0];
   assign raw[1] = word[2*FIELD_W-1:FIELD_W];

   // One clamp and one storage register per phase field; index 0 is low, 1 is high.
   for (genvar g = 0; g < 2; g++) begin : g_field
      assign eff[g] = (raw[g] == '0) ? FIELD_W'(1) : raw[g];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            act_q[g] <= FIELD_W'(1);
         else if (take)
            act_q[g] <= eff[g];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         bypass <= 1'b1;
      else if (take)
         bypass <= word[BYP_BIT];
   end

   assign lo_lim = act_q[0];
   assign hi_lim = act_q[1];
endmodule

// File: rtl/hlclk_phase_ctr.sv
module hlclk_phase_ctr #(
   parameter int unsigned FIELD_W = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [FIELD_W-1:0] hi_lim,
   input  logic [FIELD_W-1:0] lo_lim,
   input  logic               bypass,
   output logic               boundary,
   output logic               high,
   output logic [FIELD_W-1:0] cnt,
   output logic [FIELD_W-1:0] lim
);
   import hlclk_pkg::*;

   phase_e phase_q;
   logic   last;

   assign lim      = (phase_q == PH_HIGH) ? hi_lim : lo_lim;
   assign last     = (cnt == lim - FIELD_W'(1));
   assign boundary = bypass | ((phase_q == PH_LOW) & last);
   assign high     = (phase_q == PH_HIGH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_LOW;
         cnt     <= '0;
      end else if (boundary) begin
         phase_q <= PH_HIGH;
         cnt     <= '0;
      end else if (last) begin
         phase_q <= PH_LOW;
         cnt     <= '0;
      end else begin
         cnt <= cnt + FIELD_W'(1);
      end
   end
endmodule

// File: rtl/hlclk_div.sv
module hlclk_div #(
   parameter int unsigned FIELD_W = 6,
   localparam int unsigned CTRL_W  = 2 * FIELD_W + 3,
   localparam int unsigned RATIO_W = FIELD_W + 1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [CTRL_W-1:0]  ctrl_i,
   input  logic               load_i,
   output logic               clk_div_o,
   output logic [RATIO_W-1:0] ratio_o
);
   if (FIELD_W < 2 || FIELD_W > 16) begin : g_bad_width
      $error("hlclk_div: FIELD_W must lie in 2..16");
   end

   logic [CTRL_W-1:0]  pend_word;
   logic               pend_valid;
   logic               boundary;
   logic               take;
   logic [FIELD_W-1:0] hi_lim;
   logic [FIELD_W-1:0] lo_lim;
   logic               bypass;
   logic               high;
   logic [FIELD_W-1:0] cnt;
   logic [FIELD_W-1:0] lim;

   assign take = boundary & pend_valid;

   hlclk_word_hold #(.FIELD_W(FIELD_W)) u_hold (
      .clk       (clk_i),
      .rst_n     (rst_ni),
      .load      (load_i),
      .word      (ctrl_i),
      .take      (take),
      .pend_word (pend_word),
      .pend_valid(pend_valid)
   );

   hlclk_cfg_reg #(.FIELD_W(FIELD_W)) u_cfg (
      .clk   (clk_i),
      .rst_n (rst_ni),
      .take  (take),
      .word  (pend_word),
      .hi_lim(hi_lim),
      .lo_lim(lo_lim),
      .bypass(bypass)
   );

   hlclk_phase_ctr #(.FIELD_W(FIELD_W)) u_ctr (
      .clk     (clk_i),
      .rst_n   (rst_ni),
      .hi_lim  (hi_lim),
      .lo_lim  (lo_lim),
      .bypass  (bypass),
      .boundary(boundary),
      .high    (high),
      .cnt     (cnt),
      .lim     (lim)
   );

   assign clk_div_o = bypass ? (clk_i & rst_ni) : high;
   assign ratio_o   = bypass ? RATIO_W'(1)
                             : (RATIO_W'(hi_lim) + RATIO_W'(lo_lim));
endmodule

// File: rtl/hlclk_div_chk.sv
module hlclk_div_chk #(
   parameter int unsigned FIELD_W = 6,
   localparam int unsigned CTRL_W  = 2 * FIELD_W + 3,
   localparam int unsigned RATIO_W = FIELD_W + 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic [CTRL_W-1:0]  ctrl,
   input logic               load,
   input logic [RATIO_W-1:0] ratio,
   input logic               boundary,
   input logic               pend_valid,
   input logic [FIELD_W-1:0] cnt,
   input logic [FIELD_W-1:0] lim
);
   localparam int unsigned NOUPD_BIT = hlclk_pkg::pos_noupd(FIELD_W);
   localparam int unsigned MAX_RATIO = 2 * ((1 << FIELD_W) - 1);

   assert_reset_ratio_R1: assert property (@(posedge clk)
      !rst_n |=> ratio == RATIO_W'(1));

   assert_ratio_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ratio >= RATIO_W'(1)) && (ratio <= RATIO_W'(MAX_RATIO)));

   assert_count_in_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < lim);

   assert_change_at_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ratio != $past(ratio)) |-> $past(boundary));

   assert_noupd_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (load && ctrl[NOUPD_BIT] && !pend_valid) |=> !pend_valid);
endmodule

bind hlclk_div hlclk_div_chk #(.FIELD_W(FIELD_W)) u_chk (
   .clk       (clk_i),
   .rst_n     (rst_ni),
   .ctrl      (ctrl_i),
   .load      (load_i),
   .ratio     (ratio_o),
   .boundary  (boundary),
   .pend_valid(pend_valid),
   .cnt       (cnt),
   .lim       (lim)
);

// File: tb/hlclk_div_bench.sv
`timescale 1ns/1ps
module hlclk_div_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [14:0] ctrl = '0;
   logic        load = 1'b0;
   logic        clk_div;
   logic [6:0]  ratio;

   int    total = 0;
   int    bad = 0;
   int    cycles = 0;
   string cur_tag = "R1";

   hlclk_div u_hlclk_div (
      .clk_i    (clk),
      .rst_ni   (rst_n),
      .ctrl_i   (ctrl),
      .load_i   (load),
      .clk_div_o(clk_div),
      .ratio_o  (ratio)
   );

   always #10 clk = ~clk;

   // Reference model state
   int m_hi, m_lo, m_cnt;
   bit m_byp, m_high, m_pv;
   logic [14:0] m_pw;

   function automatic logic [14:0] enc(int n, bit noupd);
      int h = n / 2;
      int l = n - h;
      return {noupd, (n == 1), bit'(n % 2), 6'(h), 6'(l)};
   endfunction

   function automatic int clamp(int v);
      return (v == 0) ? 1 : v;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_hi = 1; m_lo = 1; m_byp = 1; m_high = 0; m_cnt = 0;
         m_pv = 0; m_pw = '0;
      end else begin
         bit bnd;
         bit take;
         bnd  = m_byp || (!m_high && m_cnt == m_lo - 1);
         take = bnd && m_pv;
         if (bnd) begin
            if (take) begin
               m_lo  = clamp(int'(m_pw[5:0]));
               m_hi  = clamp(int'(m_pw[11:6]));
               m_byp = m_pw[13];
            end
            m_high = 1; m_cnt = 0;
         end else if (m_high && m_cnt == m_hi - 1) begin
            m_high = 0; m_cnt = 0;
         end else begin
            m_cnt++;
         end
         if (load && !ctrl[14]) begin
            m_pw = ctrl; m_pv = 1;
         end else if (take) begin
            m_pv = 0;
         end
      end
   end

   task automatic chk(string tag, string what, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s act=%0d exp=%0d t=%0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic model_cmp();
      int exp_out = m_byp ? int'(clk & rst_n) : int'(m_high);
      int exp_rat = m_byp ? 1 : m_hi + m_lo;
      if (!rst_n) exp_out = 0;
      chk(cur_tag, "clk_div", int'(clk_div), exp_out);
      chk(cur_tag, "ratio", int'(ratio), exp_rat);
   endtask

   initial begin
      forever begin
         @(posedge clk); #5 model_cmp();
         @(negedge clk); #5 model_cmp();
      end
   end

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         total++; bad++;
         $display("FAIL watchdog (all requirements) act=%0d exp<=100000", cycles);
         finish_run();
      end
   end

   task automatic put(logic [14:0] w);
      @(negedge clk);
      ctrl = w; load = 1'b1;
      @(negedge clk);
      load = 1'b0; ctrl = '0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      cur_tag = "R1";
      idle(3);
      #5;
      chk("R1", "reset ratio", int'(ratio), 1);
      chk("R1", "reset out", int'(clk_div), 0);
      @(negedge clk); rst_n = 1'b1;

      cur_tag = "R2";
      idle(8);
      chk("R2", "bypass ratio", int'(ratio), 1);

      cur_tag = "R3";
      put(enc(4, 0)); idle(20);
      chk("R3", "ratio 4", int'(ratio), 4);
      put(enc(2, 0)); idle(12);
      chk("R3", "ratio 2", int'(ratio), 2);

      cur_tag = "R4";
      put(enc(5, 0)); idle(20);
      chk("R4", "ratio 5", int'(ratio), 5);
      put(enc(3, 0)); idle(15);
      chk("R4", "ratio 3", int'(ratio), 3);
      put(enc(5, 0)); idle(20);

      cur_tag = "R6";
      put(enc(7, 0));
      chk("R6", "held until boundary", int'(ratio), 5);
      idle(30);
      chk("R6", "applied after boundary", int'(ratio), 7);

      cur_tag = "R7";
      put(enc(9, 1)); idle(40);
      chk("R7", "noupd ignored", int'(ratio), 7);

      cur_tag = "R8";
      put(enc(6, 0) | 15'h1000); idle(30);
      chk("R8", "edge flag ignored", int'(ratio), 6);

      cur_tag = "R5";
      put({3'b000, 6'd0, 6'd3}); idle(30);
      chk("R5", "zero high", int'(ratio), 4);
      put({3'b000, 6'd5, 6'd0}); idle(30);
      chk("R5", "zero low", int'(ratio), 6);
      put({3'b000, 6'd0, 6'd0}); idle(20);
      chk("R5", "both zero", int'(ratio), 2);
      put(enc(6, 0)); idle(20);

      cur_tag = "R9";
      @(negedge clk); ctrl = enc(10, 0); load = 1'b1;
      @(negedge clk); ctrl = enc(3, 0);
      @(negedge clk); load = 1'b0; ctrl = '0;
      idle(40);
      chk("R9", "last load wins", int'(ratio), 3);

      cur_tag = "R2";
      put({3'b010, 6'd5, 6'd5}); idle(10);
      chk("R2", "bypass with fields", int'(ratio), 1);
      put(enc(3, 0)); idle(10);
      chk("R2", "leave bypass", int'(ratio), 3);

      cur_tag = "R3";
      put({3'b000, 6'd63, 6'd63}); idle(300);
      chk("R3", "max ratio", int'(ratio), 126);

      cur_tag = "R1";
      @(negedge clk); rst_n = 1'b0;
      #5;
      chk("R1", "mid-run reset out", int'(clk_div), 0);
      chk("R1", "mid-run reset ratio", int'(ratio), 1);
      @(negedge clk); rst_n = 1'b1;
      cur_tag = "R2";
      idle(6);
      finish_run();
   end
endmodule